// File: doc/BRIEF.md
# Down-Counting PWM Timer

This block produces a pulse-width-modulated level from a 24-bit down counter. The counter value is the concatenation of an 8-bit prescale extension (upper bits) and a 16-bit low part. A start value fixes the period, a match value fixes where the pulse ends, and the count restarts from the start value each time it reaches zero.

Configuration arrives as plain input levels. These are the enable, the start and match values in two parts each, polarity inversion, an option to hold off counting until a trigger arrives, an interrupt enable and an edge selector. The current count is visible on an output port. A sticky interrupt flag records qualifying edges of the uninverted waveform and is cleared by a one-cycle clear strobe.

Top module: `pwm_timer`

## Requirements
- R1: During and right after reset the count reads 0, the uninverted level is low (so `pwm_out` equals `invert`) and `irq` is low.
- R2: In the cycle after `en` is seen high (with no trigger wait), the count equals the start value. It then falls by one each clock. A count of zero is followed by the start value again, so one period lasts start+1 clocks.
- R3: The counter is 24 bits wide. `start_pre`/`match_pre` form bits 23:16 and `start_lo`/`match_lo` form bits 15:0 of the start and match values.
- R4: The uninverted level is high while the count runs from the start value down to match+1. It is low from the count equal to match down to 0.
- R5: When match is greater than or equal to start, the uninverted level stays high while counting.
- R6: A match of zero gives a high time of start clocks and a low time of one clock per period.
- R7: `pwm_out` is the uninverted level XOR `invert`.
- R8: With `wait_trig` high, an enabled block holds its count and a low level until `trig` is sampled high. In the following cycle the count equals the start value.
- R9: While `en` is low the count holds its value and the uninverted level is low. A later enable reloads the start value.
- R10: `edge_sel` picks the edges that set the flag: 2'b01 rising, 2'b10 falling, 2'b11 both, 2'b00 none. A qualifying edge of the uninverted level sets `irq` one clock after the level changes.
- R11: With `irq_en` low, no edge sets `irq`.
- R12: A high `int_clr` clears `irq` at the next clock, unless a qualifying edge sets it in that same cycle, in which case the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable |
| start_lo | input | 16 | Start value, low part |
| start_pre | input | 8 | Start value, prescale extension |
| match_lo | input | 16 | Match value, low part |
| match_pre | input | 8 | Match value, prescale extension |
| invert | input | 1 | Output polarity flip |
| wait_trig | input | 1 | Hold counting until trigger |
| trig | input | 1 | Start trigger |
| irq_en | input | 1 | Interrupt flag enable |
| edge_sel | input | 2 | Edge selector for the flag |
| int_clr | input | 1 | Flag clear strobe |
| pwm_out | output | 1 | PWM level |
| count | output | 24 | Current counter value |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The properties assume that the start and match values change only while `en` is low. The constant-level property in particular reads them as fixed across a running period. The stimulus honours this by dropping `en` for at least one clock before each new configuration. Only `invert`, `trig`, `int_clr`, `irq_en` and `edge_sel` change while the counter runs. A cycle model built from the requirements predicts count, level and flag for every clock, so reload, match, trigger gating and set-versus-clear collisions are all compared cycle by cycle.

// File: rtl/pwm_timer_pkg.sv
// Shared types for the PWM timer: edge selector codes and run-state encoding.
package pwm_timer_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'b00,
        RS_ARMED = 2'b01,
        RS_RUN   = 2'b10
    } run_state_e;

endpackage

// File: rtl/pwm_start_ctl.sv
// Start control: decides when the counter first loads its start value.
// Assumes en is a level. Load happens in the first enabled cycle, or in the
// first cycle trig is high when the trigger wait is selected.
module pwm_start_ctl
    import pwm_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic wait_trig,
    input  logic trig,
    output logic load,
    output logic running
);

    run_state_e state_q, state_d;

    // Load request: enabled, not yet running, trigger condition met.
    always_comb begin
        load = en && (state_q != RS_RUN) && (!wait_trig || trig);
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = RS_IDLE;
        end else if (load) begin
            state_d = RS_RUN;
        end else if (state_q == RS_IDLE) begin
            state_d = RS_ARMED;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign running = (state_q == RS_RUN);

endmodule

// File: rtl/pwm_down_counter.sv
// Down counter and uninverted waveform register.
// Assumes load is only raised when not already running. While disabled the
// count holds and the level is forced low.
module pwm_down_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load,
    input  logic             running,
    input  logic [CNT_W-1:0] start_val,
    input  logic [CNT_W-1:0] match_val,
    output logic [CNT_W-1:0] cnt,
    output logic             raw
);

    logic [CNT_W-1:0] cnt_nx;
    logic             raw_nx;

    // Next count: start on load or after zero, otherwise decrement.
    always_comb begin
        if (load || (cnt == '0)) begin
            cnt_nx = start_val;
        end else begin
            cnt_nx = cnt - 1'b1;
        end
    end

    // Next level: start value wins over match, else the level holds.
    always_comb begin
        if (cnt_nx == start_val) begin
            raw_nx = 1'b1;
        end else if (cnt_nx == match_val) begin
            raw_nx = 1'b0;
        end else begin
            raw_nx = raw;
        end
    end

    // Counter and level registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            raw <= 1'b0;
        end else if (!en) begin
            raw <= 1'b0;
        end else if (load || running) begin
            cnt <= cnt_nx;
            raw <= raw_nx;
        end
    end

endmodule

// File: rtl/pwm_edge_irq.sv
// Edge detector and sticky interrupt flag on the uninverted level.
// Assumes raw is registered. A flag set takes priority over a same-cycle clear.
module pwm_edge_irq
    import pwm_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw,
    input  logic       irq_en,
    input  logic [1:0] edge_sel,
    input  logic       int_clr,
    output logic       irq
);

    logic raw_q;
    logic rise, fall, hit;

    // Qualify the edge against the selector.
    always_comb begin
        rise = raw && !raw_q;
        fall = !raw && raw_q;
        hit  = irq_en
            && ((rise && edge_sel[0] && (edge_sel != EDGE_NONE))
             || (fall && edge_sel[1]));
    end

    // Delayed level and sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
            irq   <= 1'b0;
        end else begin
            raw_q <= raw;
            if (hit) begin
                irq <= 1'b1;
            end else if (int_clr) begin
                irq <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pwm_timer.sv
// Top of the down-counting PWM timer. Joins the start control, the counter
// and the interrupt flag, and applies the output polarity.
// Assumes start and match values change only while en is low.
module pwm_timer #(
    parameter int LO_W  = 16,
    parameter int PRE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic [LO_W-1:0]       start_lo,
    input  logic [PRE_W-1:0]      start_pre,
    input  logic [LO_W-1:0]       match_lo,
    input  logic [PRE_W-1:0]      match_pre,
    input  logic                  invert,
    input  logic                  wait_trig,
    input  logic                  trig,
    input  logic                  irq_en,
    input  logic [1:0]            edge_sel,
    input  logic                  int_clr,
    output logic                  pwm_out,
    output logic [LO_W+PRE_W-1:0] count,
    output logic                  irq
);

    localparam int CNT_W = LO_W + PRE_W;

    logic [CNT_W-1:0] start_full;
    logic [CNT_W-1:0] match_full;
    logic             load;
    logic             running;
    logic             raw;

    assign start_full = {start_pre, start_lo};
    assign match_full = {match_pre, match_lo};

    pwm_start_ctl u_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .wait_trig (wait_trig),
        .trig      (trig),
        .load      (load),
        .running   (running)
    );

    pwm_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .load      (load),
        .running   (running),
        .start_val (start_full),
        .match_val (match_full),
        .cnt       (count),
        .raw       (raw)
    );

    pwm_edge_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      (raw),
        .irq_en   (irq_en),
        .edge_sel (edge_sel),
        .int_clr  (int_clr),
        .irq      (irq)
    );

    assign pwm_out = raw ^ invert;

endmodule

// File: rtl/pwm_timer_chk.sv
// Property checker for pwm_timer, attached by bind below.
module pwm_timer_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             wait_trig,
    input logic             trig,
    input logic             irq_en,
    input logic             int_clr,
    input logic             invert,
    input logic [CNT_W-1:0] start_full,
    input logic [CNT_W-1:0] match_full,
    input logic [CNT_W-1:0] count,
    input logic             pwm_out,
    input logic             irq,
    input logic             running
);

    // R2
    count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && en && count != '0) |=> count == $past(count) - 1'b1);

    // R2
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && en && count == '0) |=> count == $past(start_full));

    // R9
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (count == $past(count)) && (pwm_out == invert));

    // R8
    trig_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wait_trig && !trig && !running) |=> (count == $past(count)) && !running);

    // R5
    const_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && en && $stable(start_full) && $stable(match_full)
         && match_full >= start_full) |-> (pwm_out != invert));

    // R11
    no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && !irq) |=> !irq);

    // R12
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_clr && !irq_en) |=> !irq);

endmodule

bind pwm_timer pwm_timer_chk #(.CNT_W(LO_W + PRE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .wait_trig  (wait_trig),
    .trig       (trig),
    .irq_en     (irq_en),
    .int_clr    (int_clr),
    .invert     (invert),
    .start_full ({start_pre, start_lo}),
    .match_full ({match_pre, match_lo}),
    .count      (count),
    .pwm_out    (pwm_out),
    .irq        (irq),
    .running    (running)
);

// File: tb/tb_pwm_timer.sv
// Scoreboard bench: a driver steps a cycle model and queues expectations,
// a monitor pops and compares them after each clock edge.
module tb_pwm_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [15:0] start_lo = '0;
    logic [7:0]  start_pre = '0;
    logic [15:0] match_lo = '0;
    logic [7:0]  match_pre = '0;
    logic        invert = 1'b0;
    logic        wait_trig = 1'b0;
    logic        trig = 1'b0;
    logic        irq_en = 1'b0;
    logic [1:0]  edge_sel = 2'b00;
    logic        int_clr = 1'b0;
    logic        pwm_out;
    logic [23:0] count;
    logic        irq;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    logic [23:0] q_cnt[$];
    logic        q_pwm[$];
    logic        q_irq[$];
    string       q_tag[$];

    // cycle model state
    logic        m_run = 0;
    logic [23:0] m_cnt = 0;
    logic        m_raw = 0;
    logic        m_rawq = 0;
    logic        m_irq = 0;

    always #2 clk = ~clk;

    pwm_timer dut (
        .clk(clk), .rst_n(rst_n), .en(en),
        .start_lo(start_lo), .start_pre(start_pre),
        .match_lo(match_lo), .match_pre(match_pre),
        .invert(invert), .wait_trig(wait_trig), .trig(trig),
        .irq_en(irq_en), .edge_sel(edge_sel), .int_clr(int_clr),
        .pwm_out(pwm_out), .count(count), .irq(irq)
    );

    // Advance the model by one clock with the current inputs and queue the result.
    task automatic step(input string tag);
        logic [23:0] st, mt, nc;
        logic        hit;
        st = {start_pre, start_lo};
        mt = {match_pre, match_lo};
        if (!rst_n) begin
            m_run = 0; m_cnt = 0; m_raw = 0; m_rawq = 0; m_irq = 0;
        end else begin
            hit = irq_en && ((edge_sel[0] && m_raw && !m_rawq) ||
                             (edge_sel[1] && !m_raw && m_rawq));
            if (hit) m_irq = 1;
            else if (int_clr) m_irq = 0;
            m_rawq = m_raw;
            if (!en) begin
                m_run = 0; m_raw = 0;
            end else if (!m_run) begin
                if (!wait_trig || trig) begin
                    m_run = 1; m_cnt = st; m_raw = 1;
                end
            end else begin
                nc = (m_cnt == 0) ? st : m_cnt - 1;
                if (nc == st) m_raw = 1;
                else if (nc == mt) m_raw = 0;
                m_cnt = nc;
            end
        end
        q_cnt.push_back(m_cnt);
        q_pwm.push_back(m_raw ^ invert);
        q_irq.push_back(m_irq);
        q_tag.push_back(tag);
        @(negedge clk);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    // Drop enable for two cycles so configuration can change safely.
    task automatic stop(input string tag);
        en = 0;
        run(2, tag);
    endtask

    // Monitor: compare outputs shortly after each rising edge.
    always @(posedge clk) begin
        #1;
        if (q_cnt.size() > 0) begin
            logic [23:0] ec;
            logic ep, ei;
            string t;
            ec = q_cnt.pop_front();
            ep = q_pwm.pop_front();
            ei = q_irq.pop_front();
            t  = q_tag.pop_front();
            compared++;
            if (count !== ec || pwm_out !== ep || irq !== ei) begin
                mismatched++;
                $display("FAIL %s: count=%0d pwm=%b irq=%b, expected count=%0d pwm=%b irq=%b",
                         t, count, pwm_out, irq, ec, ep, ei);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        run(3, "R1");
        rst_n = 1;
        run(2, "R1");

        // R2 / R4: basic period, start 5 match 2, rising-edge flag
        start_lo = 5; match_lo = 2; irq_en = 1; edge_sel = 2'b01;
        en = 1;
        run(14, "R2_R4");
        int_clr = 1; step("R12"); int_clr = 0;
        run(6, "R10");
        stop("R9");

        // R3: prescale extension, start 0x01_0002 match 0x00_0100
        irq_en = 0; int_clr = 1; step("R12"); int_clr = 0;
        start_pre = 1; start_lo = 2; match_pre = 0; match_lo = 16'h0100;
        en = 1;
        run(270, "R3");
        stop("R9");

        // R6: match zero
        start_pre = 0; start_lo = 4; match_lo = 0;
        en = 1;
        run(12, "R6");
        stop("R9");

        // R5: match above start, then match equal to start
        start_lo = 5; match_lo = 7;
        en = 1; run(10, "R5"); stop("R5");
        match_lo = 5;
        en = 1; run(10, "R5"); stop("R5");

        // R7: inversion, toggled while running
        start_lo = 6; match_lo = 3; invert = 1;
        en = 1; run(9, "R7");
        invert = 0; run(4, "R7");
        invert = 1; run(4, "R7");
        stop("R7");
        invert = 0;

        // R8: trigger wait
        wait_trig = 1; start_lo = 4; match_lo = 1;
        en = 1; run(5, "R8");
        trig = 1; step("R8"); trig = 0;
        run(10, "R8");
        stop("R8");
        wait_trig = 0;

        // R9: disable mid-count, hold, re-enable reloads
        start_lo = 9; match_lo = 4;
        en = 1; run(5, "R9");
        en = 0; run(4, "R9");
        en = 1; run(6, "R9");

        // R10: falling, both, none
        irq_en = 1; edge_sel = 2'b10; run(12, "R10");
        int_clr = 1; step("R10"); int_clr = 0;
        edge_sel = 2'b11; run(12, "R10");
        int_clr = 1; step("R10"); int_clr = 0;
        edge_sel = 2'b00; run(12, "R10");

        // R11: enable off, both edges selected
        irq_en = 0; edge_sel = 2'b11; run(12, "R11");

        // R12: clear held high across edges, set must win on edge cycles
        irq_en = 1; int_clr = 1; run(22, "R12");
        int_clr = 0; run(3, "R12");
        stop("R12");

        run(2, "R9");
        done = 1;
        @(posedge clk); #2;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule